// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces one black-level clamp pulse per video line. It watches a horizontal sync input, finds the end of each sync pulse, waits a programmed number of pixel clocks, and then holds the clamp output high for a programmed number of pixel clocks. Both the delay and the length are 8-bit values. A polarity select tells the block which sync level counts as the active pulse.

The sync input is asynchronous to the pixel clock, so it passes through a two-flop synchronizer before edge detection. The delay and length are captured when the end of sync is detected. A change made later in the line therefore applies from the next line on. A bypass bit hands the output to an external clamp source. In that mode the programmed delay and length have no effect on the output.

Top module: `line_clamp_gen`

## Requirements
- R1: After a synchronous reset, `clamp_out` is 0 while `ext_mode` is 0, and it stays 0 until the end of a sync pulse has been detected.
- R2: Let the first clock edge that samples `hsync_in` at its inactive level after a pulse be edge 1. With `ext_mode` = 0, `clamp_out` first goes high after rising edge P+3, where P is `place_cnt`.
- R3: With `ext_mode` = 0, once `clamp_out` goes high it stays high for exactly W pixel clocks, where W is `width_cnt` (1 to 255), unless a new end of sync arrives first.
- R4: A `place_cnt` of 0 gives the same timing as a `place_cnt` of 1.
- R5: A `width_cnt` of 0 produces no clamp pulse on that line.
- R6: The polarity select works as follows. When `hs_act_high` = 1, the sync pulse is the high level and a high-to-low change on `hsync_in` ends it. When `hs_act_high` = 0, the sync pulse is the low level and a low-to-high change ends it. The start of a sync pulse starts nothing. The polarity is changed only while reset is asserted.
- R7: When `ext_mode` = 1, `clamp_out` follows `ext_clamp_in` in the same cycle, whatever `place_cnt` and `width_cnt` hold.
- R8: An end of sync that arrives while a delay or a pulse is in progress drops the clamp and restarts the sequence, with timing measured from the new edge.
- R9: `place_cnt` and `width_cnt` are captured on the clock edge that registers the end of sync (edge 3 in the R2 numbering). Later changes in the same line do not alter that line's pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| hs_act_high | input | 1 | 1: sync pulse is the high level; 0: sync pulse is the low level |
| place_cnt | input | 8 (CNT_W) | Pixel clocks from end of sync to start of clamp |
| width_cnt | input | 8 (CNT_W) | Clamp length in pixel clocks |
| ext_mode | input | 1 | 1: output follows the external clamp input |
| ext_clamp_in | input | 1 | External clamp source |
| clamp_out | output | 1 | Clamp pulse |

## Verification
The hardest case to create from the ports is a second end of sync that lands inside a running count. It has to land once during the delay and once during the pulse itself, and each time the clamp must drop and the sequence restart from the new edge. The line driver can emit a second sync pulse inside the same line. It builds the expected waveform as the first window cut off at the restart point, joined to a fresh window measured from the second edge. The same driver can also change the delay and length a few cycles after capture. That shows the running line keeps its old values and the next line picks up the new ones.

// File: rtl/lcg_pkg.sv
// Shared definitions for the line clamp generator.
// Assumes: the count width is the same in every submodule.
package lcg_pkg;
    localparam int CNT_W_DEF = 8;

    // Timer phases: idle, waiting out the placement delay, clamp active
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_ACT  = 2'd2
    } clamp_phase_t;
endpackage

// File: rtl/lcg_hs_sync.sv
// Synchronizes the raw sync input and flags the end of each sync pulse.
// Assumes: hs_act_high is static outside reset. The chain resets to the
// inactive level so that releasing reset cannot fake an edge.
module lcg_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_raw,
    input  logic hs_act_high,
    output logic trail_pulse
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;
    logic          idle_lvl;

    assign idle_lvl = ~hs_act_high;

    // Shift register: STAGES synchronizer flops plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {(LAST + 1){idle_lvl}};
        end else begin
            chain <= {chain[LAST-1:0], hs_raw};
        end
    end

    // End of sync: the synchronized level leaves the active level
    always_comb begin
        if (hs_act_high) begin
            trail_pulse = chain[LAST] & ~chain[LAST-1];
        end else begin
            trail_pulse = ~chain[LAST] & chain[LAST-1];
        end
    end
endmodule

// File: rtl/lcg_timer.sv
// Delay-then-pulse timer. It starts on each end-of-sync flag and captures
// placement and width at that moment.
// Assumes: start is a single-cycle flag. Placement 0 acts as 1, width 0 gives
// no pulse, and a start in any phase restarts the sequence.
module lcg_timer
    import lcg_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] place,
    input  logic [CNT_W-1:0] width,
    output logic             clamp,
    output logic [CNT_W-1:0] width_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    clamp_phase_t     phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] place_eff;

    // Placement floor: zero behaves as one
    assign place_eff = (place == '0) ? ONE : place;

    // Phase and count sequencing; start has priority over every phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            width_q <= '0;
        end else if (start) begin
            width_q <= width;
            if (width == '0) begin
                phase <= PH_IDLE;
                cnt   <= '0;
            end else begin
                phase <= PH_WAIT;
                cnt   <= place_eff;
            end
        end else begin
            case (phase)
                PH_WAIT: begin
                    if (cnt == ONE) begin
                        phase <= PH_ACT;
                        cnt   <= width_q;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_ACT: begin
                    if (cnt == ONE) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // The clamp is high exactly in the active phase
    assign clamp = (phase == PH_ACT);
endmodule

// File: rtl/lcg_out_sel.sv
// Output selector: the internal pulse, or the external clamp passed through.
// Assumes: the external source is already in the pixel-clock domain.
module lcg_out_sel (
    input  logic ext_mode,
    input  logic ext_clamp_in,
    input  logic int_clamp,
    output logic clamp_out
);
    // Combinational bypass, no added latency
    assign clamp_out = ext_mode ? ext_clamp_in : int_clamp;
endmodule

// File: rtl/line_clamp_gen.sv
// Top level: sync conditioning, delay/pulse timer and output selector.
// Assumes: all inputs except hsync_in are synchronous to clk.
module line_clamp_gen
    import lcg_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             hs_act_high,
    input  logic [CNT_W-1:0] place_cnt,
    input  logic [CNT_W-1:0] width_cnt,
    input  logic             ext_mode,
    input  logic             ext_clamp_in,
    output logic             clamp_out
);
    logic             edge_flag;
    logic             clamp_int;
    logic [CNT_W-1:0] width_lat;

    lcg_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_raw      (hsync_in),
        .hs_act_high (hs_act_high),
        .trail_pulse (edge_flag)
    );

    lcg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (edge_flag),
        .place   (place_cnt),
        .width   (width_cnt),
        .clamp   (clamp_int),
        .width_q (width_lat)
    );

    lcg_out_sel u_sel (
        .ext_mode     (ext_mode),
        .ext_clamp_in (ext_clamp_in),
        .int_clamp    (clamp_int),
        .clamp_out    (clamp_out)
    );
endmodule

// File: rtl/lcg_chk.sv
// Property checker for line_clamp_gen, attached by bind.
// Assumes: it sees the edge flag, the internal clamp and the captured width.
module lcg_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trail,
    input logic             int_clamp,
    input logic [CNT_W-1:0] width_q,
    input logic             ext_mode,
    input logic             ext_clamp_in,
    input logic             clamp_out
);
    logic [CNT_W:0] run_len;

    // Length of the current high run of the internal clamp
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (int_clamp) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R7
    ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> (clamp_out == ext_clamp_in));

    // R8
    restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail |=> !int_clamp);

    // R2
    rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_clamp) |-> !$past(trail));

    // R3
    width_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(int_clamp) && !$past(trail)) |-> (run_len == {1'b0, $past(width_q)}));

    // R5
    zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_clamp) |-> (width_q != '0));
endmodule

bind line_clamp_gen lcg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trail        (edge_flag),
    .int_clamp    (clamp_int),
    .width_q      (width_lat),
    .ext_mode     (ext_mode),
    .ext_clamp_in (ext_clamp_in),
    .clamp_out    (clamp_out)
);

// File: tb/line_clamp_gen_tb.sv
`timescale 1ns/1ps
module line_clamp_gen_tb;
    typedef struct {
        logic  val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs = 1'b0;
    logic       pol = 1'b1;
    logic [7:0] place = 8'd1;
    logic [7:0] width = 8'd1;
    logic       ext_mode = 1'b0;
    logic       ext_in = 1'b0;
    logic       clamp;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    line_clamp_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hsync_in     (hs),
        .hs_act_high  (pol),
        .place_cnt    (place),
        .width_cnt    (width),
        .ext_mode     (ext_mode),
        .ext_clamp_in (ext_in),
        .clamp_out    (clamp)
    );

    // Monitor: compares each cycle's output against the scoreboard head
    always begin
        @(negedge clk);
        #1;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (clamp !== it.val) begin
                errors++;
                $display("FAIL %s: t=%0t actual=%b expected=%b", it.tag, $time, clamp, it.val);
            end
        end
    end

    function automatic int eff_place(int p);
        return (p == 0) ? 1 : p;
    endfunction

    task automatic push_exp(logic v, string tag);
        exp_t it;
        it.val = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Reset with a chosen polarity, then idle cycles that must stay low (R1)
    task automatic do_reset(logic a_hi);
        @(negedge clk);
        rst_n = 1'b0; pol = a_hi; hs = ~a_hi; ext_mode = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            push_exp(1'b0, "R1");
            @(negedge clk);
        end
    endtask

    // One line: sync for s_len cycles, an optional second sync pulse at rs_at,
    // and a placement/width change from iteration chg_i on
    task automatic run_line(string tag, int s_len, int l_len, int p, int w,
                            int p2, int w2, int chg_i, bit ext,
                            int rs_at, int rs_len);
        logic act = pol;
        int s2 = (rs_at > 0) ? rs_at + rs_len : -1000;
        int pv1 = eff_place((chg_i <= s_len + 2) ? p2 : p);
        int wv1 = (chg_i <= s_len + 2) ? w2 : w;
        int pv2 = eff_place((chg_i <= s2 + 2) ? p2 : p);
        int wv2 = (chg_i <= s2 + 2) ? w2 : w;
        for (int i = 0; i < l_len; i++) begin
            bit in1, in2;
            logic e;
            @(negedge clk);
            hs = (i < s_len || (rs_at > 0 && i >= rs_at && i < s2)) ? act : ~act;
            place = (i >= chg_i) ? p2[7:0] : p[7:0];
            width = (i >= chg_i) ? w2[7:0] : w[7:0];
            ext_mode = ext;
            ext_in = i[1] ^ i[3];
            in1 = (i >= s_len + 3 + pv1) && (i <= s_len + 2 + pv1 + wv1);
            if (rs_at > 0 && i >= s2 + 3) in1 = 0;
            in2 = (rs_at > 0) && (i >= s2 + 3 + pv2) && (i <= s2 + 2 + pv2 + wv2);
            e = ext ? ext_in : logic'(in1 || in2);
            push_exp(e, tag);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);                                   // R1, R6 active-high
        run_line("R2", 4, 40, 5, 6, 5, 6, 9999, 0, 0, 0);
        run_line("R2", 4, 20, 1, 1, 1, 1, 9999, 0, 0, 0);  // shortest timing
        run_line("R3", 4, 270, 3, 255, 3, 255, 9999, 0, 0, 0);
        run_line("R2", 4, 280, 255, 2, 255, 2, 9999, 0, 0, 0);
        run_line("R4", 4, 20, 0, 3, 0, 3, 9999, 0, 0, 0);
        run_line("R5", 4, 30, 4, 0, 4, 0, 9999, 0, 0, 0);
        run_line("R9", 4, 40, 6, 4, 2, 9, 7, 0, 0, 0);     // old values hold
        run_line("R9", 4, 40, 2, 9, 2, 9, 9999, 0, 0, 0);  // new values apply
        run_line("R8", 4, 40, 10, 5, 10, 5, 9999, 0, 8, 3);   // restart in delay
        run_line("R8", 4, 45, 2, 20, 2, 20, 9999, 0, 12, 3);  // restart in pulse
        run_line("R7", 4, 30, 3, 5, 3, 5, 9999, 1, 0, 0);
        run_line("R7", 4, 20, 0, 0, 0, 0, 9999, 1, 0, 0);
        do_reset(1'b0);                                   // R1, R6 active-low
        run_line("R6", 4, 30, 3, 4, 3, 4, 9999, 0, 0, 0);
        run_line("R6", 6, 30, 1, 7, 1, 7, 9999, 0, 0, 0);
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule